// File: doc/BRIEF.md
# Clocked 8-bit Serial Shifter

This block moves one byte in or out over a three-wire synchronous link: a shift clock, a serial input and a serial output. Software loads the byte as two 4-bit halves, picks a clock source and the pin roles in a small mode register, and then pulses a start command. The block waits for the first falling edge of the shift clock. After that, each falling edge puts the next bit on the output pin, least significant bit first, and each rising edge samples the input pin into the top of the byte. When the eighth rising edge has been counted, a completion flag goes high.

The shift clock can be produced inside the block from the system clock, at one quarter of its rate by default. It can also come from another device, through a synchronizer. Restarting a transfer that is still running aborts it, sets the completion flag, and begins a fresh count. When the pins are not given the serial role, the output pin carries a plain port bit and the shifter ignores the input pin.

Top module: `ser_shifter`

## Requirements
- R1: After reset the completion flag is 0, both data halves read 0, the mode register is 0 (internal clock, both pins in port role), `sck_out` is 1, `sck_oe` is 1, and `so` follows `port_so`.
- R2: A write with `wr_en` high stores `wr_data` according to `wr_sel`. Value 1 writes data bits 3:0, value 2 writes data bits 7:4, and value 0 writes the mode register. Bit 0 of the mode selects the external clock, bit 1 enables the serial input, and bit 2 enables the serial output. `rd_lo` and `rd_hi` show the two data halves.
- R3: `start` clears the 3-bit bit counter and arms the block. Counting begins only at the next falling shift-clock edge, and a rising edge seen while armed is ignored.
- R4: On each falling edge of a running transfer, the output presents the next data bit, LSB first. On each rising edge, the input bit enters bit 7 and the byte shifts toward bit 0.
- R5: When the counter wraps to 0 on the eighth rising edge, the flag is set and the transfer ends. The flag is still 0 before that edge.
- R6: `start` during an armed or running transfer sets the flag in the next cycle and restarts the count from 0, so that eight more rising edges are needed.
- R7: With the internal clock, `sck_out` idles high, stays high for 2 cycles after the start, then alternates 2 cycles low and 2 cycles high. The flag is set on the 32nd clock edge after the edge that samples `start`.
- R8: With the external clock, `sck_oe` is 0 and `sck_in` passes through a 2-stage synchronizer before its edges are used.
- R9: With mode bit 2 at 0, `so` equals `port_so`. With mode bit 1 at 0, the shifter takes 0 in place of `si`.
- R10: Data-half writes made while a transfer is armed or running have no effect.
- R11: `flag_clr` clears the flag. If a completion or an abort happens in the same cycle, the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 mode, 1 low half, 2 high half |
| wr_data | input | 4 | Write value |
| start | input | 1 | Start (or restart) command |
| flag_clr | input | 1 | Clears the completion flag |
| rd_lo | output | 4 | Data bits 3:0 |
| rd_hi | output | 4 | Data bits 7:4 |
| irq_flag | output | 1 | Completion flag |
| sck_in | input | 1 | External shift clock |
| sck_out | output | 1 | Internal shift clock |
| sck_oe | output | 1 | Drive enable for `sck_out` |
| si | input | 1 | Serial data input pin |
| so | output | 1 | Serial data output pin |
| port_so | input | 1 | Port value for `so` when the serial output is off |

## Verification
The flag has one setter and one clearer, and both can act in the same cycle. The bench raises `flag_clr` so that it is sampled on exactly the 32nd edge, when the eighth internal rising edge completes the transfer, and it expects the flag to read 1 afterwards. A restart and a falling clock edge are also brought together: the bench aborts in a cycle with the shift clock high. It then checks that the flag goes high at once and that the restarted count finishes 32 edges later, not earlier.

// File: rtl/ser_shifter_pkg.sv
package ser_shifter_pkg;
    localparam int DATA_W = 8;
    localparam int NIB_W  = 4;
    localparam int NIBS   = DATA_W / NIB_W;
    localparam int CNT_W  = $clog2(DATA_W);

    typedef enum logic [1:0] {
        SEL_MODE = 2'd0,
        SEL_LO   = 2'd1,
        SEL_HI   = 2'd2
    } wsel_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } xfer_e;

    typedef struct packed {
        logic so_en;
        logic si_en;
        logic clk_ext;
    } mode_t;

    typedef struct packed {
        logic fall;
        logic rise;
    } sck_evt_t;

    function automatic mode_t nib_to_mode(input logic [NIB_W-1:0] n);
        return mode_t'(n[2:0]);
    endfunction
endpackage

// File: rtl/ser_clkgen.sv
module ser_clkgen
    import ser_shifter_pkg::*;
#(
    parameter int HALF_PER    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     clk_ext,
    input  logic     busy,
    input  logic     restart,
    input  logic     sck_in,
    output sck_evt_t evt,
    output logic     sck_int
);
    localparam int HC_W = (HALF_PER > 1) ? $clog2(HALF_PER) : 1;

    logic [HC_W-1:0]        hcnt_q;
    logic                   sck_q;
    logic                   run_int;
    logic                   half_done;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   sck_s;
    sck_evt_t               int_evt;
    sck_evt_t               ext_evt;

    assign run_int   = busy && !clk_ext && !restart;
    assign half_done = (hcnt_q == HC_W'(HALF_PER - 1));

    always_ff @(posedge clk) begin
        if (rst || !run_int) begin
            hcnt_q <= '0;
            sck_q  <= 1'b1;
        end else if (half_done) begin
            hcnt_q <= '0;
            sck_q  <= ~sck_q;
        end else begin
            hcnt_q <= hcnt_q + HC_W'(1);
        end
    end

    always_comb begin
        int_evt.fall = run_int && half_done && sck_q;
        int_evt.rise = run_int && half_done && !sck_q;
    end

    generate
        if (SYNC_STAGES == 1) begin : g_sync1
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= sck_in;
            end
        end else begin : g_syncn
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], sck_in};
            end
        end
    endgenerate

    assign sck_s = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= sck_s;
    end

    always_comb begin
        ext_evt.fall = prev_q && !sck_s;
        ext_evt.rise = !prev_q && sck_s;
    end

    assign evt     = clk_ext ? ext_evt : int_evt;
    assign sck_int = sck_q;

    // R7: the generated clock rests high whenever no transfer is active
    a_r7_idle_high: assert property (@(posedge clk) disable iff (rst)
        !busy |-> sck_int);
    // R8: a settled external-clock selection keeps the internal clock parked
    a_r8_ext_parked: assert property (@(posedge clk) disable iff (rst)
        (clk_ext && $past(clk_ext)) |-> sck_int);
endmodule

// File: rtl/ser_core.sv
module ser_core
    import ser_shifter_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              flag_clr,
    input  sck_evt_t          evt,
    input  logic              si_bit,
    input  logic [NIBS-1:0]   nib_wr,
    input  logic [NIB_W-1:0]  wr_nib,
    output logic [DATA_W-1:0] data,
    output logic              so_bit,
    output logic              busy,
    output logic              flag
);
    xfer_e             st_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] sr_q;
    logic [DATA_W-1:0] sr_d;
    logic              so_q;
    logic              flag_q;
    logic              last_bit;
    logic              shift_now;
    logic              done;
    logic              abort;

    assign busy      = (st_q != ST_IDLE);
    assign last_bit  = (cnt_q == CNT_W'(DATA_W - 1));
    assign shift_now = (st_q == ST_RUN) && evt.rise && !start;
    assign done      = shift_now && last_bit;
    assign abort     = start && busy;

    always_comb begin
        sr_d = sr_q;
        if (shift_now) begin
            sr_d = {si_bit, sr_q[DATA_W-1:1]};
        end else if (!busy) begin
            for (int g = 0; g < NIBS; g++) begin
                if (nib_wr[g]) sr_d[g*NIB_W +: NIB_W] = wr_nib;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            sr_q   <= '0;
            so_q   <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            sr_q <= sr_d;
            if (done || abort)  flag_q <= 1'b1;
            else if (flag_clr)  flag_q <= 1'b0;
            if (start) begin
                st_q  <= ST_ARMED;
                cnt_q <= '0;
            end else begin
                if (busy && evt.fall) so_q <= sr_q[0];
                unique case (st_q)
                    ST_ARMED: if (evt.fall) st_q <= ST_RUN;
                    ST_RUN: begin
                        if (evt.rise) begin
                            cnt_q <= cnt_q + CNT_W'(1);
                            if (last_bit) st_q <= ST_IDLE;
                        end
                    end
                    default: st_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign data   = sr_q;
    assign so_bit = so_q;
    assign flag   = flag_q;

    // R3: a start leaves the block armed with an empty count
    a_r3_start_clears: assert property (@(posedge clk) disable iff (rst)
        start |=> (cnt_q == '0) && (st_q == ST_ARMED));
    // R6: restarting an active transfer raises the flag
    a_r6_abort_flags: assert property (@(posedge clk) disable iff (rst)
        (start && busy) |=> flag);
    // R5: the final rising edge ends the transfer with the flag up
    a_r5_done_flags: assert property (@(posedge clk) disable iff (rst)
        done |=> (flag && !busy));
    // R10: half writes during a transfer leave the byte untouched
    a_r10_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy && !evt.rise && (|nib_wr)) |=> $stable(data));
    // R4: the output bit moves only after a falling edge
    a_r4_so_on_fall: assert property (@(posedge clk) disable iff (rst)
        !$stable(so_bit) |-> $past(evt.fall));
endmodule

// File: rtl/ser_pinmux.sv
module ser_pinmux
    import ser_shifter_pkg::*;
(
    input  mode_t mode,
    input  logic  so_core,
    input  logic  port_so,
    input  logic  si_pin,
    output logic  so_pin,
    output logic  si_core,
    output logic  sck_oe
);
    assign so_pin  = mode.so_en ? so_core : port_so;
    assign si_core = mode.si_en & si_pin;
    assign sck_oe  = !mode.clk_ext;
endmodule

// File: rtl/ser_shifter.sv
module ser_shifter
    import ser_shifter_pkg::*;
#(
    parameter int HALF_PER    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [1:0] wr_sel,
    input  logic [3:0] wr_data,
    input  logic       start,
    input  logic       flag_clr,
    output logic [3:0] rd_lo,
    output logic [3:0] rd_hi,
    output logic       irq_flag,
    input  logic       sck_in,
    output logic       sck_out,
    output logic       sck_oe,
    input  logic       si,
    output logic       so,
    input  logic       port_so
);
    mode_t             mode_q;
    logic [NIBS-1:0]   nib_wr;
    logic [DATA_W-1:0] data;
    logic              so_core;
    logic              si_core;
    logic              busy;
    sck_evt_t          evt;

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= '0;
        else if (wr_en && (wr_sel == 2'(SEL_MODE)))
            mode_q <= nib_to_mode(wr_data);
    end

    generate
        for (genvar g = 0; g < NIBS; g++) begin : g_nib
            assign nib_wr[g] = wr_en && (wr_sel == (2'(SEL_LO) + 2'(g)));
        end
    endgenerate

    ser_clkgen #(
        .HALF_PER    (HALF_PER),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_clkgen (
        .clk     (clk),
        .rst     (rst),
        .clk_ext (mode_q.clk_ext),
        .busy    (busy),
        .restart (start),
        .sck_in  (sck_in),
        .evt     (evt),
        .sck_int (sck_out)
    );

    ser_core u_core (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .flag_clr (flag_clr),
        .evt      (evt),
        .si_bit   (si_core),
        .nib_wr   (nib_wr),
        .wr_nib   (wr_data),
        .data     (data),
        .so_bit   (so_core),
        .busy     (busy),
        .flag     (irq_flag)
    );

    ser_pinmux u_pinmux (
        .mode    (mode_q),
        .so_core (so_core),
        .port_so (port_so),
        .si_pin  (si),
        .so_pin  (so),
        .si_core (si_core),
        .sck_oe  (sck_oe)
    );

    assign rd_lo = data[3:0];
    assign rd_hi = data[7:4];
endmodule

// File: tb/ser_shifter_bench.sv
module ser_shifter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 2;
    localparam int XFER_CYC   = 2 * HALF * 8;
    localparam int EXT_HALF   = 6;
    localparam int LIMIT      = 100000;

    logic       clk = 1'b0;
    logic       rst, wr_en, start, flag_clr, sck_in, si, port_so;
    logic [1:0] wr_sel;
    logic [3:0] wr_data, rd_lo, rd_hi;
    logic       irq_flag, sck_out, sck_oe, so;

    int         total = 0;
    int         fails = 0;
    int         cyc = 0;
    logic       dev_on = 1'b0;
    int         dev_idx = 0;
    logic [7:0] dev_byte = 8'h00;
    logic [7:0] cap = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    ser_shifter u_ser_shifter (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .start(start), .flag_clr(flag_clr), .rd_lo(rd_lo), .rd_hi(rd_hi),
        .irq_flag(irq_flag), .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe),
        .si(si), .so(so), .port_so(port_so)
    );

    // peer device on the internally generated clock
    always @(negedge sck_out) if (dev_on && dev_idx < 8) si = dev_byte[dev_idx];
    always @(posedge sck_out) if (dev_on) begin
        if (dev_idx < 8) cap[dev_idx] = so;
        dev_idx++;
    end

    task automatic report();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > LIMIT) begin
            total++; fails++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cyc, LIMIT);
            report();
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rx(input logic si_on, input logic [7:0] dev);
        return si_on ? dev : 8'h00;
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [3:0] val);
        wr_en = 1'b1; wr_sel = sel; wr_data = val;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1; tick(); flag_clr = 1'b0;
        chk("R11 clear", {31'd0, irq_flag}, 32'd1 - 32'd1);
    endtask

    task automatic pulse_start();
        start = 1'b1; tick(); start = 1'b0;
    endtask

    // internal-clock transfer; mid_wr tries half writes, clr_hit clears on the final edge
    task automatic run_int(input logic [7:0] tx, input logic [7:0] dev, input logic si_on,
                           input logic mid_wr, input logic clr_hit);
        wr(2'd1, tx[3:0]);
        wr(2'd2, tx[7:4]);
        chk("R2 data", {24'd0, rd_hi, rd_lo}, {24'd0, tx});
        dev_byte = dev; dev_idx = 0; dev_on = 1'b1;
        pulse_start();
        for (int k = 1; k <= XFER_CYC; k++) begin
            tick();
            if (k == 2)  chk("R7 first fall", {31'd0, sck_out}, 32'd0);
            if (k == 4)  chk("R7 first rise", {31'd0, sck_out}, 32'd1);
            if (mid_wr && k == 10) begin wr_en = 1'b1; wr_sel = 2'd1; wr_data = 4'hF; end
            if (mid_wr && k == 11) wr_sel = 2'd2;
            if (mid_wr && k == 12) wr_en = 1'b0;
            if (k == XFER_CYC - 1) begin
                chk("R5 early", {31'd0, irq_flag}, 32'd0);
                if (clr_hit) flag_clr = 1'b1;
            end
            if (k == XFER_CYC) begin
                flag_clr = 1'b0;
                chk(clr_hit ? "R11 set wins" : "R5 R7 done", {31'd0, irq_flag}, 32'd1);
            end
        end
        dev_on = 1'b0;
        chk("R4 rx", {24'd0, rd_hi, rd_lo}, {24'd0, exp_rx(si_on, dev)});
        chk("R4 tx stream", {24'd0, cap}, {24'd0, tx});
        chk("R7 idle", {31'd0, sck_out}, 32'd1);
        clear_flag();
    endtask

    task automatic run_ext(input logic [7:0] tx, input logic [7:0] dev, input logic pre_rise);
        logic [7:0] got;
        got = 8'h00;
        wr(2'd1, tx[3:0]);
        wr(2'd2, tx[7:4]);
        sck_in = 1'b1;
        if (pre_rise) begin sck_in = 1'b0; repeat (EXT_HALF) tick(); end
        pulse_start();
        if (pre_rise) begin sck_in = 1'b1; repeat (EXT_HALF) tick(); end
        for (int i = 0; i < 8; i++) begin
            sck_in = 1'b0; si = dev[i];
            repeat (EXT_HALF) tick();
            got[i] = so;
            if (i == 7) chk("R3 R5 no early flag", {31'd0, irq_flag}, 32'd0);
            sck_in = 1'b1;
            repeat (EXT_HALF) tick();
        end
        chk("R8 done", {31'd0, irq_flag}, 32'd1);
        chk("R8 rx", {24'd0, rd_hi, rd_lo}, {24'd0, dev});
        chk("R8 tx stream", {24'd0, got}, {24'd0, tx});
        clear_flag();
    endtask

    initial begin
        logic [7:0] a, b;
        void'($urandom(32'h0000_5EED));
        rst = 1'b1; wr_en = 1'b0; wr_sel = 2'd0; wr_data = 4'h0; start = 1'b0;
        flag_clr = 1'b0; sck_in = 1'b1; si = 1'b0; port_so = 1'b0;
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R1 reset state
        chk("R1 flag", {31'd0, irq_flag}, 32'd0);
        chk("R1 data", {24'd0, rd_hi, rd_lo}, 32'd0);
        chk("R1 sck", {30'd0, sck_out, sck_oe}, 32'd3);
        port_so = 1'b1; #1;
        chk("R1 R9 so port", {31'd0, so}, 32'd1);
        port_so = 1'b0; #1;
        chk("R9 so port low", {31'd0, so}, 32'd0);

        // R2 half writes
        wr(2'd1, 4'hA);
        wr(2'd2, 4'h5);
        chk("R2 lo", {28'd0, rd_lo}, 32'hA);
        chk("R2 hi", {28'd0, rd_hi}, 32'h5);

        // serial pins on, internal clock
        wr(2'd0, 4'h6);
        port_so = 1'b1; #1;
        chk("R9 so serial", {31'd0, so}, 32'd0);
        port_so = 1'b0;
        run_int(8'h3C, 8'hA5, 1'b1, 1'b0, 1'b0);
        run_int(8'h01, 8'h80, 1'b1, 1'b0, 1'b0);
        for (int n = 0; n < 16; n++) begin
            a = 8'($urandom); b = 8'($urandom);
            run_int(a, b, 1'b1, 1'b0, 1'b0);
        end

        // R10 writes during transfer
        run_int(8'h12, 8'h6B, 1'b1, 1'b1, 1'b0);
        // R11 clear and completion together
        run_int(8'hF0, 8'h0F, 1'b1, 1'b0, 1'b1);

        // R6 abort and restart
        wr(2'd1, 4'h7); wr(2'd2, 4'hC);
        dev_byte = 8'h99; dev_idx = 0; dev_on = 1'b1;
        pulse_start();
        repeat (12) tick();
        chk("R6 before abort", {31'd0, irq_flag}, 32'd0);
        start = 1'b1; dev_byte = 8'h4E; dev_idx = 0;
        tick();
        start = 1'b0;
        chk("R6 abort flag", {31'd0, irq_flag}, 32'd1);
        flag_clr = 1'b1; tick(); flag_clr = 1'b0;
        chk("R11 clear after abort", {31'd0, irq_flag}, 32'd0);
        repeat (XFER_CYC - 2) tick();
        chk("R3 R6 restarted count", {31'd0, irq_flag}, 32'd0);
        tick();
        chk("R6 restart done", {31'd0, irq_flag}, 32'd1);
        chk("R6 restart rx", {24'd0, rd_hi, rd_lo}, 32'h4E);
        dev_on = 1'b0;
        clear_flag();

        // R9 serial input disabled
        wr(2'd0, 4'h4);
        run_int(8'h5A, 8'hFF, 1'b0, 1'b0, 1'b0);

        // R8 external clock
        wr(2'd0, 4'h7);
        tick();
        chk("R8 oe off", {31'd0, sck_oe}, 32'd0);
        chk("R8 sck parked", {31'd0, sck_out}, 32'd1);
        run_ext(8'hC3, 8'h96, 1'b1);
        for (int n = 0; n < 3; n++) begin
            a = 8'($urandom); b = 8'($urandom);
            run_ext(a, b, 1'b0);
        end

        report();
        $finish;
    end
endmodule